// File: doc/BRIEF.md
# Division-Free Residue Generator

This block reduces a binary word to its residue modulo 2^k−1 or modulo 2^k+1, chosen per cycle by a select input. No divider is used. With the default group width of 3 it produces the word modulo 7 or modulo 9. The generator is purely combinational, so its output follows its input with no clock. It is meant to sit beside an arithmetic unit or a converter's output bus, where a concurrent checker compares residues.

The input word is zero-padded and cut into k-bit groups. For 2^k−1 every group carries weight one, because 2^k ≡ 1. The groups are folded by a chain of k-bit adders whose carry-out re-enters as carry-in. An all-ones fold is the second code for zero and is mapped to 0.

For 2^k+1 the group weights alternate +1, −1, +1, …, because 2^k ≡ −1. Odd-index groups are subtracted by feeding their inverted bits into a signed accumulator with a carry-in of one. A bounded correction stage then adds or subtracts the modulus until the value lies in 0..2^k.

Top module: `resgen_top`

## Requirements
- R1: With `selPlus` = 0, `residue` equals `dataIn` mod (2^GRP−1), and its top bit is 0.
- R2: In the 2^GRP−1 mode, a fold that ends with all ones is reported as 0. For example, with GRP = 3, the inputs 0x07 and 0x3F give 0.
- R3: With `selPlus` = 1, `residue` equals `dataIn` mod (2^GRP+1) and never exceeds 2^GRP.
- R4: In the 2^GRP+1 mode, a negative alternating sum is corrected upward. For example, with GRP = 3, 0x38 gives 2 and 0x08 gives 8.
- R5: In the 2^GRP+1 mode, an alternating sum at or above the modulus is corrected downward. For example, with GRP = 3, 0xC7 gives 1.
- R6: A zero input gives a zero residue in both modes.
- R7: With WIDTH = 4 and GRP = 2, the 2^GRP−1 mode gives the residue modulo 3. For example, 0011→0, 0111→1, 1000→2 and 1111→0.
- R8: The output settles within the same clock phase as an input change; there is no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | WIDTH | Word to be reduced |
| selPlus | input | 1 | 0 selects modulus 2^GRP−1, 1 selects 2^GRP+1 |
| residue | output | GRP+1 | Canonical residue |

## Verification
The assertions assume that `dataIn` and `selPlus` carry known values, and they are skipped while either input holds X. The assertions compare the output with the `%` operator of the language. That comparison is only meaningful once both inputs are driven, so the bench drives both before its first check and holds them steady between clock edges. The stimulus stays within the parameter set used at elaboration, and the mod-3 instance is given its own narrow input.

// File: rtl/resgen_pkg.sv
package resgen_pkg;
  typedef struct packed {
    logic pickMinus;
    logic pickPlus;
  } resgen_ctrl_t;
endpackage

// File: rtl/resgen_eac_add.sv
module resgen_eac_add #(
  parameter int W = 3
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sumOut
);
  logic [W:0] rawSum;
  assign rawSum = {1'b0, opA} + {1'b0, opB};
  // carry-out wraps back as carry-in; cannot overflow again
  assign sumOut = rawSum[W-1:0] + W'(rawSum[W]);
endmodule

// File: rtl/resgen_ctrl.sv
module resgen_ctrl
  import resgen_pkg::*;
(
  input  logic         selPlus,
  output resgen_ctrl_t ctrl
);
  always_comb begin
    ctrl.pickMinus = ~selPlus;
    ctrl.pickPlus  = selPlus;
  end
endmodule

// File: rtl/resgen_datapath.sv
module resgen_datapath
  import resgen_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int GRP   = 3
) (
  input  logic [WIDTH-1:0] dataIn,
  input  resgen_ctrl_t     ctrl,
  output logic [GRP:0]     residue
);
  localparam int NGRP    = (WIDTH + GRP - 1) / GRP;
  localparam int PADW    = NGRP * GRP;
  localparam int SUMW    = GRP + 2 + $clog2(NGRP + 1);
  localparam int PLUSMOD = (1 << GRP) + 1;
  localparam int SPAN    = ((1 << GRP) - 1) * ((NGRP + 1) / 2);
  localparam int CORR    = SPAN / PLUSMOD + 1;

  logic [PADW-1:0] padded;
  logic [GRP-1:0]  grp [NGRP];
  logic [GRP-1:0]  eacAcc [NGRP];
  logic signed [SUMW-1:0] altAcc [NGRP];
  logic [GRP-1:0]  minusRes;
  logic signed [SUMW-1:0] plusWork;

  assign padded = PADW'(dataIn);

  for (genvar g = 0; g < NGRP; g++) begin : g_split
    assign grp[g] = padded[g*GRP +: GRP];
  end

  // 2^k-1 path: end-around-carry chain
  assign eacAcc[0] = grp[0];
  for (genvar g = 1; g < NGRP; g++) begin : g_eac
    resgen_eac_add #(.W(GRP)) u_add (
      .opA   (eacAcc[g-1]),
      .opB   (grp[g]),
      .sumOut(eacAcc[g])
    );
  end
  assign minusRes = (eacAcc[NGRP-1] == '1) ? '0 : eacAcc[NGRP-1];

  // 2^k+1 path: alternating signs, subtraction by inversion plus carry-in
  assign altAcc[0] = SUMW'(grp[0]);
  for (genvar g = 1; g < NGRP; g++) begin : g_alt
    if (g % 2 == 0) begin : g_add
      assign altAcc[g] = altAcc[g-1] + SUMW'(grp[g]);
    end else begin : g_sub
      assign altAcc[g] = altAcc[g-1] + ~SUMW'(grp[g]) + SUMW'(1);
    end
  end

  always_comb begin
    plusWork = altAcc[NGRP-1];
    for (int i = 0; i < CORR; i++) begin
      if (plusWork < 0)
        plusWork = plusWork + SUMW'(PLUSMOD);
      else if (plusWork >= SUMW'(PLUSMOD))
        plusWork = plusWork - SUMW'(PLUSMOD);
    end
  end

  assign residue = ({1'b0, minusRes} & {(GRP+1){ctrl.pickMinus}})
                 | (plusWork[GRP:0] & {(GRP+1){ctrl.pickPlus}});
endmodule

// File: rtl/resgen_top.sv
module resgen_top
  import resgen_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int GRP   = 3
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic             selPlus,
  output logic [GRP:0]     residue
);
  resgen_ctrl_t ctrl;

  resgen_ctrl u_ctrl (
    .selPlus(selPlus),
    .ctrl   (ctrl)
  );

  resgen_datapath #(.WIDTH(WIDTH), .GRP(GRP)) u_dp (
    .dataIn (dataIn),
    .ctrl   (ctrl),
    .residue(residue)
  );
endmodule

// File: rtl/resgen_checker.sv
module resgen_checker #(
  parameter int WIDTH = 8,
  parameter int GRP   = 3
) (
  input logic [WIDTH-1:0] dataIn,
  input logic             selPlus,
  input logic [GRP:0]     residue
);
  localparam int MINUSMOD = (1 << GRP) - 1;
  localparam int PLUSMOD  = (1 << GRP) + 1;

  logic [WIDTH:0] refMinus;
  logic [WIDTH:0] refPlus;
  logic [WIDTH:0] resWide;
  assign refMinus = {1'b0, dataIn} % (WIDTH+1)'(MINUSMOD);
  assign refPlus  = {1'b0, dataIn} % (WIDTH+1)'(PLUSMOD);
  assign resWide  = (WIDTH+1)'(residue);

  always_comb begin
    if (!$isunknown({dataIn, selPlus})) begin
      if (!selPlus) begin
        AST_MINUS_CONGRUENT: assert (resWide == refMinus && residue[GRP] == 1'b0); // R1
        if (dataIn == WIDTH'(MINUSMOD))
          AST_ALLONES_ZERO: assert (residue == '0); // R2
      end else begin
        AST_PLUS_CONGRUENT: assert (resWide == refPlus); // R3
        AST_PLUS_RANGE: assert (resWide <= (WIDTH+1)'(PLUSMOD - 1)); // R5
      end
      if (dataIn == '0)
        AST_ZERO_IN: assert (residue == '0); // R6
    end
  end
endmodule

bind resgen_top resgen_checker #(.WIDTH(WIDTH), .GRP(GRP)) u_chk (
  .dataIn (dataIn),
  .selPlus(selPlus),
  .residue(residue)
);

// File: tb/test_resgen_top.sv
module test_resgen_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [7:0] dataIn = '0;
  logic       selPlus = 1'b0;
  logic [3:0] residue;
  logic [3:0] dataIn3 = '0;
  logic       selPlus3 = 1'b0;
  logic [2:0] residue3;

  resgen_top i_resgen_top (.dataIn(dataIn), .selPlus(selPlus), .residue(residue));
  resgen_top #(.WIDTH(4), .GRP(2)) i_resgen_top_m3 (
    .dataIn(dataIn3), .selPlus(selPlus3), .residue(residue3));

  // {selPlus, data, expected}
  localparam logic [12:0] VEC [14] = '{
    {1'b0, 8'h00, 4'd0}, {1'b0, 8'h07, 4'd0}, {1'b0, 8'h3F, 4'd0},
    {1'b0, 8'hFF, 4'd3}, {1'b0, 8'h64, 4'd2}, {1'b0, 8'hC8, 4'd4},
    {1'b0, 8'hB4, 4'd5}, {1'b1, 8'hFF, 4'd3}, {1'b1, 8'h38, 4'd2},
    {1'b1, 8'hC7, 4'd1}, {1'b1, 8'h09, 4'd0}, {1'b1, 8'h08, 4'd8},
    {1'b1, 8'h80, 4'd2}, {1'b1, 8'hB4, 4'd0}
  };

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: data=%0h sel=%0b got %0d expected %0d", req, dataIn, selPlus, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R6 zero minus", int'(residue), 0);
    selPlus = 1'b1;
    #1 check("R6 zero plus", int'(residue), 0);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 14; i++) begin
      @(posedge clk);
      {selPlus, dataIn} = VEC[i][12:4];
      @(negedge clk);
      check(VEC[i][12] ? "R3/R4/R5 table" : "R1/R2 table", int'(residue), int'(VEC[i][3:0]));
    end

    // R8: change without any clock edge between drive and sample
    @(posedge clk);
    #1 selPlus = 1'b0; dataIn = 8'd100;
    #1 check("R8 same phase", int'(residue), 2);
    dataIn = 8'd200;
    #1 check("R8 same phase", int'(residue), 4);

    // exhaustive sweep, both moduli
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 256; d++) begin
        @(posedge clk);
        selPlus = s[0];
        dataIn = d[7:0];
        @(negedge clk);
        if (s == 0) check("R1 sweep", int'(residue), d % 7);
        else        check("R3 sweep", int'(residue), d % 9);
      end
    end

    // R7: narrow instance, modulus 3
    selPlus3 = 1'b0;
    dataIn3 = 4'b0011; #1 check("R7 0011", int'(residue3), 0);
    dataIn3 = 4'b0111; #1 check("R7 0111", int'(residue3), 1);
    dataIn3 = 4'b1000; #1 check("R7 1000", int'(residue3), 2);
    dataIn3 = 4'b1111; #1 check("R7 1111", int'(residue3), 0);
    selPlus3 = 1'b1;
    for (int d = 0; d < 16; d++) begin
      dataIn3 = d[3:0];
      #1 check("R3 mod5", int'(residue3), d % 5);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule